// File: doc/BRIEF.md
# Serial Receiver with Eight-Byte Queue

This block is the receive half of an asynchronous serial port. It watches one serial input line and uses a tick running at sixteen times the bit rate. A falling edge is taken as a possible start bit, and the start bit is confirmed half a bit later. The block then shifts in 5 to 8 data bits, least significant bit first. An optional parity bit follows, then the stop bit. Every character that arrives is written into an eight-byte queue, including characters whose parity or stop bit was wrong. Sticky flags record these errors. A further sticky flag records an overrun, which happens when a character arrives while the queue is already full.

Software reads one byte at a time with a single-cycle read strobe and watches the not-empty flag. An interrupt line rises once the queue holds a chosen number of bytes and stays high until an acknowledge strobe. The acknowledge also clears all error flags. If the fill condition still holds after an acknowledge, the interrupt comes back on the next cycle. Dropping the receive enable empties the queue and stops the receiver.

Top module: `uart_rx_fifo8`

## Requirements
- R1: The queue holds up to 8 bytes. `rd_data` shows the oldest stored byte, and each `rd` strobe while the queue is not empty removes exactly one byte.
- R2: `not_empty` is 1 whenever at least one byte is stored. It goes to 0 after a read only when that read removed the last byte.
- R3: A character that completes while the queue holds 8 bytes replaces the newest stored byte, and `err_overrun` is set and stays set.
- R4: When `par_en` is 1, a parity bit follows the data. `par_odd`=0 makes the total number of ones in data plus parity even, and `par_odd`=1 makes it odd. A mismatch sets the sticky `err_parity`, and the byte is still stored.
- R5: A stop bit sampled low sets the sticky `err_stop`, and the byte is still stored.
- R6: While `rx_en` is 0 the queue is empty and no character is received.
- R7: With `irq_en` at 1, `irq` rises once the queue holds at least 1, 2, 4 or 8 bytes, for `irq_mode` 0, 1, 2 or 3. Once high, `irq` stays high until an acknowledge, even if the queue is drained.
- R8: An `ack` strobe clears `err_parity`, `err_overrun`, `err_stop` and `irq` in the next cycle. If the enabled fill condition still holds, `irq` returns high one cycle later.
- R9: A low pulse on `rxd` that has ended before the mid-point of the start bit is ignored and stores nothing.
- R10: Reading while the queue is empty shows the most recently received byte, and the read does not move the queue's read position.
- R11: `char_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, received least significant bit first. Unused upper bits of the stored byte are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | Pulse at sixteen times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receive enable; 0 empties the queue |
| char_len | input | 2 | Data bits: 0=5, 1=6, 2=7, 3=8 |
| par_en | input | 1 | A parity bit is present |
| par_odd | input | 1 | 0=even parity, 1=odd parity |
| irq_mode | input | 2 | Fill threshold: 1, 2, 4 or 8 bytes |
| irq_en | input | 1 | Receive interrupt enable |
| ack | input | 1 | Clears the sticky flags and the interrupt |
| rd | input | 1 | Single-cycle read strobe |
| rd_data | output | 8 | Oldest stored byte, or the last received byte when empty |
| not_empty | output | 1 | Queue holds at least one byte |
| err_parity | output | 1 | Sticky parity error |
| err_overrun | output | 1 | Sticky overrun |
| err_stop | output | 1 | Sticky bad stop bit |
| irq | output | 1 | Sticky interrupt request |

## Verification
A wrong read or write position shows up at the next read as a byte that does not match the scoreboard, so it is found after one character time at most. A wrong fill count shows in the same cycle at `not_empty` or `irq`, and at the latest when the threshold or overrun tests reach the full queue. A receiver that loses bit alignment stores wrong values or raises a false error flag on the character it is receiving. The bench therefore checks every byte it sends and checks the flags after every frame.

// File: rtl/uart_rx_fifo8.sv
module uart_rx_fifo8 #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic [1:0] irq_mode,
  input  logic       irq_en,
  input  logic       ack,
  input  logic       rd,
  output logic [7:0] rd_data,
  output logic       not_empty,
  output logic       err_parity,
  output logic       err_overrun,
  output logic       err_stop,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(OSR);
  localparam logic [TW-1:0] T_LAST = TW'(OSR - 1);
  localparam logic [TW-1:0] T_HALF = TW'(OSR / 2 - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} rx_state_t;

  rx_state_t       st;
  logic [TW-1:0]   tcnt;
  logic [2:0]      nbit;
  logic [7:0]      sh;
  logic            pacc, perr_r;
  logic            push, push_perr, push_serr;
  logic [7:0]      push_byte;

  logic [7:0]      mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CW-1:0]   count;
  logic [7:0]      last_byte;
  logic            pop, full_ovr, thr_hit;

  assign push_byte = sh >> (2'd3 - char_len);
  assign pop       = rd && (count != 0);
  assign full_ovr  = push && (count == CW'(DEPTH)) && !pop;
  assign not_empty = (count != 0);
  assign rd_data   = not_empty ? mem[rd_ptr] : last_byte;
  assign thr_hit   = irq_en && ({1'b0, count} >= ((CW+1)'(1) << irq_mode));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; tcnt <= '0; nbit <= '0; sh <= '0;
      pacc <= 1'b0; perr_r <= 1'b0; push <= 1'b0;
      push_perr <= 1'b0; push_serr <= 1'b0;
    end else begin
      push <= 1'b0;
      if (!rx_en) begin
        st <= S_IDLE;
      end else if (baud_tick) begin
        tcnt <= tcnt + 1'b1;
        case (st)
          S_IDLE: if (!rxd) begin
            st <= S_START; tcnt <= '0; nbit <= '0; pacc <= 1'b0; perr_r <= 1'b0;
          end
          S_START: if (tcnt == T_HALF) begin
            tcnt <= '0;
            st   <= rxd ? S_IDLE : S_DATA;
          end
          S_DATA: if (tcnt == T_LAST) begin
            sh   <= {rxd, sh[7:1]};
            pacc <= pacc ^ rxd;
            if (nbit == {1'b1, char_len}) st <= par_en ? S_PAR : S_STOP;
            else nbit <= nbit + 1'b1;
          end
          S_PAR: if (tcnt == T_LAST) begin
            perr_r <= (pacc ^ rxd) != par_odd;
            st     <= S_STOP;
          end
          S_STOP: if (tcnt == T_LAST) begin
            push      <= 1'b1;
            push_perr <= par_en && perr_r;
            push_serr <= !rxd;
            st        <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[full_ovr ? wr_ptr - 1'b1 : wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; last_byte <= '0;
    end else if (!rx_en) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (push) last_byte <= push_byte;
      if (push && !full_ovr) wr_ptr <= wr_ptr + 1'b1;
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(push && !full_ovr) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_parity <= 1'b0; err_overrun <= 1'b0; err_stop <= 1'b0; irq <= 1'b0;
    end else begin
      err_parity  <= (err_parity  && !ack) || (push && push_perr);
      err_stop    <= (err_stop    && !ack) || (push && push_serr);
      err_overrun <= (err_overrun && !ack) || full_ovr;
      irq         <= ack ? 1'b0 : (irq || thr_hit);
    end
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && push && !rd && rx_en) |=> (count == CW'(DEPTH))); // R3
  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(count) == CW'(DEPTH)); // R3
  AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !not_empty); // R6
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq && !err_parity && !err_stop); // R8
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !not_empty && rx_en) |=> $stable(rd_ptr)); // R10
endmodule

// File: tb/uart_rx_fifo8_bench.sv
module uart_rx_fifo8_bench;
  localparam int CLK_NS = 10;
  localparam int BIT_CYC = 64;

  logic clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0, rxd = 1'b1, rx_en = 1'b0;
  logic [1:0] char_len = 2'd3, irq_mode = 2'd0;
  logic par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b0, ack = 1'b0, rd = 1'b0;
  logic [7:0] rd_data;
  logic not_empty, err_parity, err_overrun, err_stop, irq;

  int total = 0, bad = 0;
  logic [7:0] q[$];
  logic [7:0] last_rx = 8'h00;
  logic [1:0] tdiv = '0;
  bit done = 0;

  uart_rx_fifo8 u_uart_rx_fifo8 (.*);

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    baud_tick <= (tdiv == 2'd3);
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rxd = v;
    repeat (BIT_CYC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit flip_par = 0, input bit bad_stop = 0);
    int n = int'(char_len) + 5;
    logic [7:0] d = b & ((8'h1 << n) - 8'h1);
    logic p = ^d ^ par_odd;
    send_bit(1'b0);
    for (int i = 0; i < n; i++) send_bit(d[i]);
    if (par_en) send_bit(p ^ flip_par);
    if (bad_stop) begin
      rxd = 1'b0; repeat (40) @(negedge clk);
      send_bit(1'b1);
    end else send_bit(1'b1);
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    if (q.size() == 8) q[7] = d; else q.push_back(d);
    last_rx = d;
  endtask

  task automatic read_one(input string tag);
    logic [7:0] e;
    @(negedge clk);
    e = (q.size() != 0) ? q.pop_front() : last_rx;
    check(rd_data == e, tag, rd_data, e);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
  endtask

  task automatic drain(input string tag);
    while (q.size() != 0) read_one(tag);
  endtask

  task automatic pulse_ack;
    @(negedge clk); ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(!not_empty && !irq && !err_parity && !err_overrun && !err_stop,
          "R2 reset state", {not_empty, irq, err_parity, err_overrun, err_stop}, 0);
    rst_n = 1'b1; rx_en = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hA5); send(8'h3C); send(8'hFF);
    check(not_empty, "R2 not_empty after frames", not_empty, 1);
    read_one("R1 order");
    check(not_empty, "R2 still not_empty", not_empty, 1);
    drain("R1 order");
    check(!not_empty, "R2 empty after last read", not_empty, 0);

    read_one("R10 empty read shows last");
    read_one("R10 second empty read");
    send(8'h12);
    read_one("R10 pointers unchanged");

    char_len = 2'd0; par_en = 1'b1; par_odd = 1'b0; send(8'hFB);
    char_len = 2'd2; par_odd = 1'b1; send(8'hD5);
    char_len = 2'd1; par_en = 1'b0; send(8'hEE);
    check(!err_parity && !err_stop, "R4 no error on good parity", err_parity, 0);
    drain("R11 char length");

    char_len = 2'd3; par_en = 1'b1; par_odd = 1'b0;
    send(8'h0A, 1'b1);
    check(err_parity, "R4 parity error sticky", err_parity, 1);
    read_one("R4 byte kept despite parity error");
    check(err_parity, "R4 flag survives read", err_parity, 1);
    pulse_ack; @(negedge clk);
    check(!err_parity, "R8 ack clears parity", err_parity, 0);
    par_en = 1'b0;

    send(8'h77, 1'b0, 1'b1);
    check(err_stop, "R5 bad stop sticky", err_stop, 1);
    read_one("R5 byte kept despite bad stop");
    check(!not_empty, "R9 no frame from post-stop glitch", not_empty, 0);
    pulse_ack; @(negedge clk);
    check(!err_stop, "R8 ack clears stop flag", err_stop, 0);

    for (int i = 0; i < 8; i++) send(8'h80 + 8'(i));
    check(!err_overrun, "R3 no overrun at exactly 8", err_overrun, 0);
    send(8'h5A);
    check(err_overrun, "R3 overrun set", err_overrun, 1);
    drain("R3 newest overwrites last slot");
    check(err_overrun, "R3 overrun sticky", err_overrun, 1);
    pulse_ack; @(negedge clk);
    check(!err_overrun, "R8 ack clears overrun", err_overrun, 0);

    irq_en = 1'b1; irq_mode = 2'd2;
    send(8'h01); send(8'h02); send(8'h03);
    check(!irq, "R7 below threshold 4", irq, 1'b0);
    send(8'h04);
    check(irq, "R7 threshold 4 reached", irq, 1'b1);
    pulse_ack;
    check(!irq, "R8 irq low after ack", irq, 0);
    @(negedge clk);
    check(irq, "R8 irq refires while condition holds", irq, 1);
    drain("R7 data");
    check(irq, "R7 irq sticky after drain", irq, 1);
    pulse_ack; repeat (3) @(negedge clk);
    check(!irq, "R8 irq stays low once condition gone", irq, 0);

    irq_mode = 2'd3;
    for (int i = 0; i < 7; i++) send(8'h40 + 8'(i));
    check(!irq, "R7 below threshold 8", irq, 0);
    send(8'h47);
    check(irq, "R7 threshold 8 reached", irq, 1);
    drain("R7 data 8");
    pulse_ack;
    irq_mode = 2'd0; send(8'h99);
    check(irq, "R7 threshold 1 reached", irq, 1);

    irq_en = 1'b0; pulse_ack;
    @(negedge clk); rx_en = 1'b0; @(negedge clk); rx_en = 1'b1;
    q.delete();
    @(negedge clk);
    check(!not_empty, "R6 disable empties queue", not_empty, 0);
    rx_en = 1'b0; send(8'h33); q.delete(); rx_en = 1'b1;
    @(negedge clk);
    check(!not_empty, "R6 no reception while disabled", not_empty, 0);

    rxd = 1'b0; repeat (8) @(negedge clk); rxd = 1'b1;
    repeat (2 * BIT_CYC) @(negedge clk);
    check(!not_empty, "R9 short glitch ignored", not_empty, 0);
    send(8'hC3);
    read_one("R9 clean frame after glitch");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule